// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator Bank

This block drives a parameterised bank of 8-bit pulse-width modulators (4, 8 or 16 channels) from one 24 MHz system clock. Every channel owns a period register, a duty register and a time-base selector. The selector picks one of four fixed tick rates: every cycle, every 16th cycle, every 256th cycle, or every 750th cycle, which gives about 32 kHz. It can pick a fifth tick instead, which comes from a shared programmable divider. That divider counts ticks of one selected fixed rate and divides them by a value from 1 to 255. All slower rates are single-cycle enables, so there is only one clock domain.

A host reaches the block through a parallel write/read port. Each output edge sets a sticky flag for its channel. The flags drive a shared active-low interrupt and are cleared by reading the status byte that holds them.

Top module: `pwmBank`

## Requirements
- R1: After reset every PWM output is low, the interrupt output is high, and every register reads 0.
- R2: Each channel counts 0 to P-1 on its tick, where P is the period and a period of 0 behaves as 1. The output is high while the count is below the duty value D, so over whole periods the output is high for D of every P ticks.
- R3: A duty of 0 holds the output low. A duty equal to or above the period holds it high.
- R4: Writes to period or duty take effect only when the current period completes. The running period finishes with the old values.
- R5: The channel selector (address 4+4*ch+2, bits 2:0) sets the tick rate. Code 0 ticks every cycle, code 1 every 16 cycles, code 2 every 256 cycles and code 3 every 750 cycles.
- R6: Selector codes 4 to 7 use the programmable divider. Its source (address 3, bits 1:0) takes codes 0 to 3 with the same rates as in R5. Its divisor N (address 2) gives one tick per N source ticks, and N = 0 acts as 1.
- R7: Each change of a channel's output sets that channel's flag, which stays set until cleared. The interrupt output is low whenever any flag is set.
- R8: A read of address 0 returns the flags of channels 0 to 7, and a read of address 1 returns those of channels 8 to 15, bit i being channel 8+i. The read clears exactly the flags it returns. A change in the same cycle as the read keeps its flag set.
- R9: Reads return data in the cycle after the read strobe. Period (offset 0), duty (offset 1), selector (offset 2), divisor and divider source read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, registered |
| pwmOut | output | NUM_CH | PWM outputs, one per channel |
| irqN | output | 1 | Active-low interrupt, low while any change flag is set |

## Verification
The bench counts high cycles and rising edges over windows that span whole output periods. The high count measures the duty ratio, and the edge count measures the tick rate, so the two separate a wrong duty compare from a wrong time base. Duty patterns of 1/4, 3/4, 0, equal to the period and above the period tell the compare from its two saturation cases. A period of 2 on each fixed rate, and on the divider with divisors 3, 0 and 255, catches wrong prescaler taps and divider off-by-one errors. One channel gets a duty write in the middle of a period to show that the value is only latched at the next boundary. A single edge on channel 9 shows that flags are sticky, that the interrupt follows the flags, and that clearing on read works per byte.

// File: rtl/pwmBankPkg.sv
package pwmBankPkg;
  localparam int RES_W = 8;

  localparam int STAT_LO = 0;
  localparam int STAT_HI = 1;
  localparam int DIV_VAL = 2;
  localparam int DIV_SRC = 3;
  localparam int CH_BASE = 4;

  typedef logic [RES_W-1:0] pwmVal_t;

  typedef enum logic [2:0] {
    SEL_SYS    = 3'd0,
    SEL_DIV16  = 3'd1,
    SEL_DIV256 = 3'd2,
    SEL_SLOW   = 3'd3,
    SEL_PROG   = 3'd4
  } clkSel_e;

  typedef struct packed {
    pwmVal_t    period;
    pwmVal_t    duty;
    logic [2:0] clkSel;
  } chCfg_t;

  typedef struct packed {
    pwmVal_t    divVal;
    logic [1:0] divSrc;
  } divCfg_t;
endpackage

// File: rtl/pwmTimeBase.sv
module pwmTimeBase import pwmBankPkg::*; #(
  parameter int PRE_W    = 4,
  parameter int SLOW_DIV = 750
) (
  input  logic       clk,
  input  logic       rstN,
  input  divCfg_t    divCfg,
  output logic [4:0] enVec
);
  localparam int PRE_CNT_W = 2 * PRE_W;
  localparam int SLOW_W    = $clog2(SLOW_DIV);

  logic [PRE_CNT_W-1:0] preCnt;
  logic [SLOW_W-1:0]    slowCnt;
  logic [RES_W-1:0]     divCnt;
  logic [3:0]           baseEn;
  logic                 srcEn, divLast, divTick;
  logic [RES_W-1:0]     effDiv;

  always_comb begin
    baseEn[0] = 1'b1;
    baseEn[1] = &preCnt[PRE_W-1:0];
    baseEn[2] = &preCnt;
    baseEn[3] = (slowCnt == SLOW_W'(SLOW_DIV - 1));
    srcEn     = baseEn[divCfg.divSrc];
    effDiv    = (divCfg.divVal == '0) ? RES_W'(1) : divCfg.divVal;
    divLast   = ({1'b0, divCnt} + (RES_W+1)'(1)) >= {1'b0, effDiv};
    divTick   = srcEn && divLast;
    enVec     = {divTick, baseEn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      slowCnt <= '0;
      divCnt  <= '0;
    end else begin
      preCnt  <= preCnt + 1'b1;
      slowCnt <= baseEn[3] ? '0 : slowCnt + 1'b1;
      if (srcEn) divCnt <= divLast ? '0 : divCnt + 1'b1;
    end
  end

  p_nested_rate_r5: assert property (@(posedge clk) disable iff (!rstN)
    baseEn[2] |-> baseEn[1]);
  p_slow_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    baseEn[3] |=> !baseEn[3]);
  p_div_on_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    enVec[4] |-> enVec[divCfg.divSrc]);
endmodule

// File: rtl/pwmChannel.sv
module pwmChannel import pwmBankPkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  pwmVal_t cfgPeriod,
  input  pwmVal_t cfgDuty,
  output logic    pwmOut,
  output logic    outChange
);
  pwmVal_t        cnt, actPeriod, actDuty;
  logic           outPrev, wrap;
  logic [RES_W:0] cntInc;

  always_comb begin
    cntInc    = {1'b0, cnt} + (RES_W+1)'(1);
    wrap      = cntInc >= {1'b0, actPeriod};
    pwmOut    = cnt < actDuty;
    outChange = pwmOut != outPrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      actPeriod <= '0;
      actDuty   <= '0;
      outPrev   <= 1'b0;
    end else begin
      outPrev <= pwmOut;
      if (tick) begin
        if (wrap) begin
          cnt       <= '0;
          actPeriod <= cfgPeriod;
          actDuty   <= cfgDuty;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rstN)
    (actPeriod > 1) |-> (cnt < actPeriod));
  p_hold_midperiod_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(tick && wrap) |=> ($stable(actPeriod) && $stable(actDuty)));
endmodule

// File: rtl/pwmDatapath.sv
module pwmDatapath import pwmBankPkg::*; #(
  parameter int NUM_CH   = 4,
  parameter int PRE_W    = 4,
  parameter int SLOW_DIV = 750
) (
  input  logic              clk,
  input  logic              rstN,
  input  chCfg_t            chCfg [NUM_CH],
  input  divCfg_t           divCfg,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] outChange
);
  logic [4:0] enVec;

  pwmTimeBase #(.PRE_W(PRE_W), .SLOW_DIV(SLOW_DIV)) u_timeBase (
    .clk(clk), .rstN(rstN), .divCfg(divCfg), .enVec(enVec)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic chTick;
    always_comb begin
      case (chCfg[g].clkSel)
        SEL_SYS:    chTick = enVec[0];
        SEL_DIV16:  chTick = enVec[1];
        SEL_DIV256: chTick = enVec[2];
        SEL_SLOW:   chTick = enVec[3];
        default:    chTick = enVec[4];
      endcase
    end

    pwmChannel u_ch (
      .clk(clk), .rstN(rstN), .tick(chTick),
      .cfgPeriod(chCfg[g].period), .cfgDuty(chCfg[g].duty),
      .pwmOut(pwmOut[g]), .outChange(outChange[g])
    );
  end
endmodule

// File: rtl/pwmCtrl.sv
module pwmCtrl import pwmBankPkg::*; #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [NUM_CH-1:0] outChange,
  output chCfg_t            chCfg [NUM_CH],
  output divCfg_t           divCfg,
  output logic              irqN
);
  logic [NUM_CH-1:0] chFlags;
  logic [15:0]       flagsWide, clrMask;
  logic [ADDR_W-1:0] chOff, chIdx;
  logic [1:0]        fieldSel;
  logic              chHit, rdLo, rdHi;
  logic [7:0]        rdNext;

  always_comb begin
    chHit     = addr >= ADDR_W'(CH_BASE);
    chOff     = addr - ADDR_W'(CH_BASE);
    chIdx     = chOff >> 2;
    fieldSel  = chOff[1:0];
    rdLo      = rdEn && (addr == ADDR_W'(STAT_LO));
    rdHi      = rdEn && (addr == ADDR_W'(STAT_HI));
    clrMask   = {{8{rdHi}}, {8{rdLo}}};
    flagsWide = '0;
    flagsWide[NUM_CH-1:0] = chFlags;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCfg <= '0;
      for (int i = 0; i < NUM_CH; i++) chCfg[i] <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_W'(DIV_VAL)) divCfg.divVal <= wrData;
      if (addr == ADDR_W'(DIV_SRC)) divCfg.divSrc <= wrData[1:0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (chHit && chIdx == ADDR_W'(i)) begin
          case (fieldSel)
            2'd0:    chCfg[i].period <= wrData;
            2'd1:    chCfg[i].duty   <= wrData;
            2'd2:    chCfg[i].clkSel <= wrData[2:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (addr == ADDR_W'(STAT_LO)) rdNext = flagsWide[7:0];
    if (addr == ADDR_W'(STAT_HI)) rdNext = flagsWide[15:8];
    if (addr == ADDR_W'(DIV_VAL)) rdNext = divCfg.divVal;
    if (addr == ADDR_W'(DIV_SRC)) rdNext = {6'b0, divCfg.divSrc};
    for (int i = 0; i < NUM_CH; i++) begin
      if (chHit && chIdx == ADDR_W'(i)) begin
        case (fieldSel)
          2'd0:    rdNext = chCfg[i].period;
          2'd1:    rdNext = chCfg[i].duty;
          2'd2:    rdNext = {5'b0, chCfg[i].clkSel};
          default: rdNext = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chFlags <= '0;
      rdData  <= '0;
    end else begin
      chFlags <= (chFlags & ~clrMask[NUM_CH-1:0]) | outChange;
      if (rdEn) rdData <= rdNext;
    end
  end

  assign irqN = ~|chFlags;

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> ((chFlags & $past(chFlags)) == $past(chFlags)));
  p_flag_cleared_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdLo && !outChange[0]) |=> !chFlags[0]);
  p_change_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    outChange[0] |=> (chFlags[0] && !irqN));
endmodule

// File: rtl/pwmBank.sv
module pwmBank import pwmBankPkg::*; #(
  parameter int NUM_CH   = 4,
  parameter int SLOW_DIV = 750,
  parameter int PRE_W    = 4,
  parameter int ADDR_W   = $clog2(CH_BASE + 4 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [NUM_CH-1:0] pwmOut,
  output logic              irqN
);
  chCfg_t            chCfg [NUM_CH];
  divCfg_t           divCfg;
  logic [NUM_CH-1:0] outChange;

  pwmCtrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .outChange(outChange),
    .chCfg(chCfg), .divCfg(divCfg), .irqN(irqN)
  );

  pwmDatapath #(.NUM_CH(NUM_CH), .PRE_W(PRE_W), .SLOW_DIV(SLOW_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .chCfg(chCfg), .divCfg(divCfg),
    .pwmOut(pwmOut), .outChange(outChange)
  );
endmodule

// File: tb/pwmBank_bench.sv
module pwmBank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int AW  = 7;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           wrEn = 1'b0, rdEn = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [7:0]     wrData = '0;
  logic [7:0]     rdData;
  logic [NCH-1:0] pwmOut;
  logic           irqN;

  int totalCnt = 0;
  int failCnt  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmBank #(.NUM_CH(NCH), .ADDR_W(AW)) u_pwmBank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut), .irqN(irqN)
  );

  task automatic chk(input string req, input int act, input int exp);
    totalCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input int a, output int d);
    @(negedge clk);
    rdEn = 1'b1; addr = AW'(a);
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic cfgCh(input int ch, input int per, input int duty, input int sel);
    wrReg(4 + 4*ch, per);
    wrReg(4 + 4*ch + 1, duty);
    wrReg(4 + 4*ch + 2, sel);
  endtask

  task automatic measure(input int ch, input int win, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    @(negedge clk);
    prev = pwmOut[ch];
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (pwmOut[ch]) highs++;
      if (pwmOut[ch] && !prev) rises++;
      prev = pwmOut[ch];
    end
  endtask

  task automatic testReset();
    int d;
    chk("R1 outputs low", int'(pwmOut), 0);
    chk("R1 irqN high", int'(irqN), 1);
    rdReg(4 + 4*3, d);
    chk("R1 period reads 0", d, 0);
    rdReg(2, d);
    chk("R1 divisor reads 0", d, 0);
  endtask

  task automatic testReadback();
    int d;
    cfgCh(15, 8'h5A, 8'h33, 5);
    wrReg(2, 8'h77);
    wrReg(3, 2);
    rdReg(4 + 60, d);     chk("R9 period", d, 8'h5A);
    rdReg(4 + 60 + 1, d); chk("R9 duty", d, 8'h33);
    rdReg(4 + 60 + 2, d); chk("R9 selector", d, 5);
    rdReg(2, d);          chk("R9 divisor", d, 8'h77);
    rdReg(3, d);          chk("R9 divider source", d, 2);
  endtask

  task automatic testDuty();
    int h, r;
    cfgCh(0, 4, 1, 0);
    repeat (20) @(negedge clk);
    measure(0, 400, h, r);
    chk("R2 duty 1/4 highs", h, 100);
    chk("R2 duty 1/4 rises", r, 100);
    wrReg(5, 3);
    repeat (20) @(negedge clk);
    measure(0, 400, h, r);
    chk("R2 duty 3/4 highs", h, 300);
  endtask

  task automatic testExtremes();
    int h, r;
    cfgCh(0, 6, 0, 0);
    repeat (20) @(negedge clk);
    measure(0, 120, h, r);
    chk("R3 duty 0 highs", h, 0);
    wrReg(5, 6);
    repeat (20) @(negedge clk);
    measure(0, 120, h, r);
    chk("R3 duty=period highs", h, 120);
    wrReg(5, 255);
    repeat (20) @(negedge clk);
    measure(0, 120, h, r);
    chk("R3 duty>period highs", h, 120);
    chk("R3 duty>period no edges", r, 0);
  endtask

  task automatic testRates();
    int h, r;
    cfgCh(1, 2, 1, 1);
    repeat (100) @(negedge clk);
    measure(1, 320, h, r);
    chk("R5 div16 rises", r, 10);
    chk("R5 div16 highs", h, 160);
    cfgCh(2, 2, 1, 2);
    repeat (1200) @(negedge clk);
    measure(2, 2048, h, r);
    chk("R5 div256 rises", r, 4);
    cfgCh(3, 2, 1, 3);
    repeat (3200) @(negedge clk);
    measure(3, 6000, h, r);
    chk("R5 slow rises", r, 4);
    chk("R5 slow highs", h, 3000);
  endtask

  task automatic testProg();
    int h, r;
    wrReg(3, 1);
    wrReg(2, 3);
    cfgCh(4, 2, 1, 4);
    repeat (300) @(negedge clk);
    measure(4, 384, h, r);
    chk("R6 div3 of div16 rises", r, 4);
    chk("R6 div3 of div16 highs", h, 192);
    wrReg(3, 0);
    wrReg(2, 0);
    cfgCh(4, 4, 1, 4);
    repeat (300) @(negedge clk);
    measure(4, 40, h, r);
    chk("R6 divisor 0 acts as 1 rises", r, 10);
    wrReg(2, 255);
    cfgCh(4, 2, 1, 7);
    repeat (1100) @(negedge clk);
    measure(4, 1020, h, r);
    chk("R6 divisor 255 rises", r, 2);
    chk("R6 divisor 255 highs", h, 510);
  endtask

  task automatic testLatch();
    int h, r, waited;
    cfgCh(5, 2, 1, 2);
    waited = 0;
    @(negedge clk);
    while (!pwmOut[5] && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    while (pwmOut[5] && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    while (!pwmOut[5] && waited < 6000) begin
      @(negedge clk);
      waited++;
    end
    wrReg(4 + 20 + 1, 0);
    repeat (100) @(negedge clk);
    chk("R4 old duty holds mid-period", int'(pwmOut[5]), 1);
    repeat (600) @(negedge clk);
    measure(5, 1024, h, r);
    chk("R4 new duty after boundary", h, 0);
  endtask

  task automatic testIrq();
    int d;
    for (int c = 0; c < 6; c++) wrReg(4 + 4*c + 1, 0);
    wrReg(4 + 60 + 1, 0);
    repeat (4000) @(negedge clk);
    rdReg(0, d);
    rdReg(1, d);
    chk("R7 irqN high once cleared", int'(irqN), 1);
    rdReg(0, d);
    chk("R8 status low cleared", d, 0);
    cfgCh(9, 4, 4, 0);
    repeat (5) @(negedge clk);
    chk("R7 irqN low after change", int'(irqN), 0);
    repeat (50) @(negedge clk);
    chk("R7 flag sticky", int'(irqN), 0);
    rdReg(0, d);
    chk("R8 low byte excludes ch9", d, 0);
    chk("R8 low-byte read keeps ch9 flag", int'(irqN), 0);
    rdReg(1, d);
    chk("R8 high byte ch9 bit", d, 8'h02);
    chk("R7 irqN high after read", int'(irqN), 1);
    rdReg(1, d);
    chk("R8 flag stays cleared", d, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testDuty();
    testExtremes();
    testRates();
    testProg();
    testLatch();
    testIrq();
    finished = 1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end
endmodule